// File: doc/BRIEF.md
# Capacitive-Sense Scan Sequencer

This block is the digital sequencer that sits in front of a 16-channel capacitive-sense converter. Software programs a control word, a channel mask, a compare threshold and a fixed channel number through a small register port. A start event, which is either a rising edge on one of 16 trigger inputs or a software start bit, launches a run. During the run the sequencer drives the converter with a start pulse, a channel index and a conversion length, and it adds up a programmable number of raw samples for each channel.

When the samples for a channel are complete, the saturated 16-bit sum goes to the result register and the conversion-done flag is set. The result is then compared against the threshold. Four modes are available: a one-shot conversion on the fixed channel, one ascending pass over the masked channels, repeated conversion on the fixed channel, and repeated passes over the masked channels. The two repeating modes stop by themselves when the compare flag becomes set. Three sticky flags feed a single interrupt line through per-flag enables.

Top module: `tsc_seq_top`

## Requirements
- R1: After reset every register reads 0, the busy bit is 0, `irq` is 0 and `conv_start` is 0.
- R2: Control word at address 0: [0] busy/go, [1] enable, [3:2] mode, [5:4] rate, [8:6] accumulate, [12:9] start source, [13] compare enable, [14] compare polarity, [15] done irq enable, [16] end-of-scan irq enable, [17] compare irq enable, [18] done flag, [19] end-of-scan flag, [20] compare flag. Address 1 holds the channel mask, address 2 the threshold, address 3 the fixed channel (bits [3:0]), and address 4 is the read-only result. Bit 0 reads 1 exactly while a run is in progress.
- R3: Mode 0 makes one conversion on the fixed channel and then returns to idle.
- R4: Mode 1 converts each channel whose mask bit is 1 once, in ascending index order, and sets the end-of-scan flag after the last one. An all-zero mask sets the end-of-scan flag at once and issues no conversion.
- R5: Modes 2 (fixed channel) and 3 (masked channels, wrapping to the lowest) repeat until enable is written 0 or the compare flag becomes set. Busy is 0 in the cycle after enable is cleared.
- R6: Accumulate codes 0,1,2,3,4,5 take 1,4,8,16,32,64 samples per channel. Codes 6 and 7 take 64.
- R7: Rate codes 0,1,2,3 drive `conv_len` to 12,13,14,16, and only that many low bits of each raw sample are added.
- R8: The sum saturates at 0xFFFF. It is written to the result register on the same edge that sets the done flag.
- R9: With compare enable set, the compare flag is set when result > threshold (polarity 0) or result <= threshold (polarity 1). With compare enable clear, it is never set by hardware.
- R10: Start source code k accepts a rising edge on `trig_in[k]`. Code 0 also accepts a control write with bit 0 set. Start events are ignored while busy or while enable is 0.
- R11: A control write loads the three flags from bits [20:18]: 0 clears a flag and 1 forces it set.
- R12: `irq` is the OR of each flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| trig_in | input | 16 | External start triggers |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | 4 | Channel to convert |
| conv_len | output | 5 | Conversion length in converter clocks |
| conv_done | input | 1 | Converter sample-valid pulse |
| conv_sample | input | 16 | Raw converter sample |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the converter raises `conv_done` only in answer to an issued start, once per start. They also assume that software does not rewrite the mode, mask or accumulate fields while a run is in progress; only clearing enable is expected mid-run. The bench converter model answers every start with exactly one done pulse three cycles later and returns a programmed per-channel sample. Each scenario writes its full configuration while the block is idle, and the only mid-run write is the one that clears enable.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_MASK   = 3'd1;
    localparam logic [2:0] A_THRESH = 3'd2;
    localparam logic [2:0] A_CHAN   = 3'd3;
    localparam logic [2:0] A_RESULT = 3'd4;

    // samples summed per channel for an accumulate code
    function automatic logic [6:0] samples_for(input logic [2:0] code);
        case (code)
            3'd0:    return 7'd1;
            3'd1:    return 7'd4;
            3'd2:    return 7'd8;
            3'd3:    return 7'd16;
            3'd4:    return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    // conversion length / result width for a rate code
    function automatic logic [4:0] bits_for(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd12;
            2'd1:    return 5'd13;
            2'd2:    return 5'd14;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/tsc_trig_sel.sv
module tsc_trig_sel #(
    parameter int NUM_CH = 16,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] trig_in,
    input  logic [CHW-1:0]    src,
    output logic              rise_o
);
    logic [NUM_CH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = trig_in;
        rise_o = trig_in[src] & ~prev_q[src];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tsc_chan_pick.sv
module tsc_chan_pick #(
    parameter int NUM_CH = 16,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask_i,
    input  logic              above_i,
    input  logic [CHW-1:0]    floor_i,
    output logic              found_o,
    output logic [CHW-1:0]    idx_o
);
    logic [NUM_CH-1:0] cand;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
        assign cand[g] = mask_i[g] && (!above_i || (g > int'(floor_i)));
    end

    // lowest qualifying index wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found_o = 1'b1;
                idx_o   = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
    parameter int DW = 16,
    parameter int MAXS_LOG2 = 6,
    localparam int AW = DW + MAXS_LOG2 + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] sample,
    input  logic [4:0]    nbits,
    output logic [DW-1:0] sum_sat
);
    logic [AW-1:0] acc_d, acc_q;
    logic [DW-1:0] keep;

    always_comb begin
        for (int i = 0; i < DW; i++) keep[i] = (i < int'(nbits));
        acc_d = acc_q;
        if (clr)      acc_d = '0;
        else if (add) acc_d = acc_q + AW'(sample & keep);
        sum_sat = (|acc_q[AW-1:DW]) ? '1 : acc_q[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clr) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/tsc_seq_top.sv
module tsc_seq_top
    import tsc_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DW = 16,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] trig_in,
    output logic              conv_start,
    output logic [CHW-1:0]    conv_chan,
    output logic [4:0]        conv_len,
    input  logic              conv_done,
    input  logic [DW-1:0]     conv_sample,
    output logic              irq
);
    typedef struct packed {
        seq_state_e        st;
        logic [CHW-1:0]    chan;
        logic [6:0]        cnt;
        logic              en;
        logic [1:0]        mode;
        logic [1:0]        rate;
        logic [2:0]        acc;
        logic [CHW-1:0]    src;
        logic              cmp_en;
        logic              cmp_pol;
        logic              done_ie;
        logic              eos_ie;
        logic              cmp_ie;
        logic              done_f;
        logic              eos_f;
        logic              cmp_f;
        logic [NUM_CH-1:0] mask;
        logic [DW-1:0]     thresh;
        logic [CHW-1:0]    chsel;
        logic [DW-1:0]     result;
    } regs_t;

    regs_t d, q;

    logic           trig_rise;
    logic           first_found, next_found;
    logic [CHW-1:0] first_idx, next_idx;
    logic           acc_clr, acc_add;
    logic [DW-1:0]  sum_sat;
    logic           hit, sw_go, start_ok, halt;
    logic [6:0]     n_samp;

    tsc_trig_sel #(.NUM_CH(NUM_CH)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src(q.src), .rise_o(trig_rise)
    );

    tsc_chan_pick #(.NUM_CH(NUM_CH)) u_first (
        .mask_i(q.mask), .above_i(1'b0), .floor_i(q.chan),
        .found_o(first_found), .idx_o(first_idx)
    );

    tsc_chan_pick #(.NUM_CH(NUM_CH)) u_next (
        .mask_i(q.mask), .above_i(1'b1), .floor_i(q.chan),
        .found_o(next_found), .idx_o(next_idx)
    );

    tsc_accum #(.DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
        .sample(conv_sample), .nbits(bits_for(q.rate)), .sum_sat(sum_sat)
    );

    assign conv_start = (q.st == ST_ISSUE);
    assign conv_chan  = q.chan;
    assign conv_len   = bits_for(q.rate);
    assign irq        = (q.done_f & q.done_ie) | (q.eos_f & q.eos_ie) | (q.cmp_f & q.cmp_ie);

    always_comb begin
        d       = q;
        acc_clr = 1'b0;
        acc_add = 1'b0;
        n_samp  = samples_for(q.acc);
        hit     = q.cmp_en && (q.cmp_pol ? (sum_sat <= q.thresh) : (sum_sat > q.thresh));
        sw_go   = wr_en && (wr_addr == A_CTRL) && wr_data[0];
        halt    = 1'b0;

        // register port
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    d.en      = wr_data[1];
                    d.mode    = wr_data[3:2];
                    d.rate    = wr_data[5:4];
                    d.acc     = wr_data[8:6];
                    d.src     = wr_data[9 +: CHW];
                    d.cmp_en  = wr_data[13];
                    d.cmp_pol = wr_data[14];
                    d.done_ie = wr_data[15];
                    d.eos_ie  = wr_data[16];
                    d.cmp_ie  = wr_data[17];
                    d.done_f  = wr_data[18];
                    d.eos_f   = wr_data[19];
                    d.cmp_f   = wr_data[20];
                end
                A_MASK:   d.mask   = wr_data[NUM_CH-1:0];
                A_THRESH: d.thresh = wr_data[DW-1:0];
                A_CHAN:   d.chsel  = wr_data[CHW-1:0];
                default: ;
            endcase
        end

        start_ok = d.en && (q.st == ST_IDLE) && (trig_rise || (sw_go && (d.src == '0)));

        // sequencer
        case (q.st)
            ST_IDLE: begin
                acc_clr = 1'b1;
                if (start_ok) begin
                    d.cnt = '0;
                    if (d.mode[0]) begin
                        if (first_found) begin
                            d.chan = first_idx;
                            d.st   = ST_ISSUE;
                        end else begin
                            d.eos_f = 1'b1;
                        end
                    end else begin
                        d.chan = d.chsel;
                        d.st   = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    acc_add = 1'b1;
                    if (7'(q.cnt + 7'd1) == n_samp) begin
                        d.st = ST_FINISH;
                    end else begin
                        d.cnt = 7'(q.cnt + 7'd1);
                        d.st  = ST_ISSUE;
                    end
                end
            end
            default: begin
                acc_clr  = 1'b1;
                d.cnt    = '0;
                d.result = sum_sat;
                d.done_f = 1'b1;
                if (hit) d.cmp_f = 1'b1;
                halt = q.mode[1] && d.cmp_f;
                if (!q.mode[0]) begin
                    d.st = (q.mode[1] && !halt) ? ST_ISSUE : ST_IDLE;
                end else if (next_found) begin
                    d.chan = next_idx;
                    d.st   = halt ? ST_IDLE : ST_ISSUE;
                end else begin
                    d.eos_f = 1'b1;
                    if (q.mode[1] && !halt && first_found) begin
                        d.chan = first_idx;
                        d.st   = ST_ISSUE;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
        endcase

        if (!d.en) d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[0]          = (q.st != ST_IDLE);
                rd_data[1]          = q.en;
                rd_data[3:2]        = q.mode;
                rd_data[5:4]        = q.rate;
                rd_data[8:6]        = q.acc;
                rd_data[9 +: CHW]   = q.src;
                rd_data[13]         = q.cmp_en;
                rd_data[14]         = q.cmp_pol;
                rd_data[15]         = q.done_ie;
                rd_data[16]         = q.eos_ie;
                rd_data[17]         = q.cmp_ie;
                rd_data[18]         = q.done_f;
                rd_data[19]         = q.eos_f;
                rd_data[20]         = q.cmp_f;
            end
            A_MASK:   rd_data[NUM_CH-1:0] = q.mask;
            A_THRESH: rd_data[DW-1:0]     = q.thresh;
            A_CHAN:   rd_data[CHW-1:0]    = q.chsel;
            A_RESULT: rd_data[DW-1:0]     = q.result;
            default: ;
        endcase
    end

    // R4
    scan_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && q.mode[0]) |-> q.mask[conv_chan]);

    // R5
    cont_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_FINISH) && q.mode[1] && hit) |=> (q.st == ST_IDLE));

    // R5
    disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.en) |-> (q.st == ST_IDLE));

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> (q.cnt < samples_for(q.acc)));
endmodule

// File: tb/tsc_seq_top_tb.sv
`timescale 1ns/1ps
module tsc_seq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] trig_in = '0;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic [4:0]  conv_len;
    logic        conv_done = 1'b0;
    logic [15:0] conv_sample = '0;
    logic        irq;

    always #2 clk = ~clk;

    tsc_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .trig_in(trig_in), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_len(conv_len), .conv_done(conv_done),
        .conv_sample(conv_sample), .irq(irq)
    );

    // converter model
    logic [15:0] samp_val [16];
    int          nstarts = 0;
    int          chlog [8];
    logic [4:0]  last_len = '0;
    int          tmr = 0;
    logic [3:0]  cur_ch = '0;

    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (tmr != 0) begin
            tmr <= tmr - 1;
            if (tmr == 1) begin
                conv_done   <= 1'b1;
                conv_sample <= samp_val[cur_ch];
            end
        end
        if (rst_n && conv_start) begin
            cur_ch <= conv_chan;
            tmr    <= 3;
            if (nstarts < 8) chlog[nstarts] = int'(conv_chan);
            nstarts  = nstarts + 1;
            last_len <= conv_len;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input int go, input int en, input int mode,
        input int rate, input int acc, input int src, input int ce, input int pol,
        input int die, input int eie, input int cie, input int flags = 0);
        logic [31:0] v = '0;
        v[0] = go[0]; v[1] = en[0]; v[3:2] = mode[1:0]; v[5:4] = rate[1:0];
        v[8:6] = acc[2:0]; v[12:9] = src[3:0]; v[13] = ce[0]; v[14] = pol[0];
        v[15] = die[0]; v[16] = eie[0]; v[17] = cie[0]; v[20:18] = flags[2:0];
        return v;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int k;
        repeat (2) @(negedge clk);
        for (k = 0; k < 5000; k++) begin
            rd(3'd0, v);
            if (!v[0]) break;
            @(negedge clk);
        end
        if (k == 5000) chk({req, " run ends"}, 32'd1, 32'd0);
    endtask

    task automatic reset_run();
        wr(3'd0, 32'd0);
        repeat (6) @(negedge clk);
        nstarts = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd4, v); chk("R1 result", v, 0);
        rd(3'd1, v); chk("R1 mask", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 conv_start", {31'd0, conv_start}, 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        reset_run();
        samp_val[6] = 16'h1ABC;
        wr(3'd3, 32'd6);
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        wait_idle("R3");
        chk("R3 one conversion", nstarts, 1);
        chk("R3 channel", chlog[0], 6);
        chk("R7 len 12", {27'd0, last_len}, 12);
        rd(3'd4, v); chk("R7 12-bit mask", v, 32'h0ABC);
        rd(3'd0, v); chk("R2 done flag/busy", {v[18], v[0]}, 2'b10);
        chk("R12 irq done", {31'd0, irq}, 1);
        // 13-bit rate
        reset_run();
        samp_val[9] = 16'hFFFF;
        wr(3'd3, 32'd9);
        wr(3'd0, ctl(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0));
        wait_idle("R7");
        chk("R7 len 13", {27'd0, last_len}, 13);
        rd(3'd4, v); chk("R7 13-bit mask", v, 32'h1FFF);
        chk("R12 irq masked", {31'd0, irq}, 0);
    endtask

    task automatic t_accum();
        logic [31:0] v;
        reset_run();
        samp_val[2] = 16'h1000;
        wr(3'd3, 32'd2);
        wr(3'd0, ctl(1, 1, 0, 3, 1, 0, 0, 0, 0, 0, 0));
        wait_idle("R6");
        chk("R6 four samples", nstarts, 4);
        chk("R7 len 16", {27'd0, last_len}, 16);
        rd(3'd4, v); chk("R6 sum of 4", v, 32'h4000);
        reset_run();
        samp_val[2] = 16'h0800;
        wr(3'd0, ctl(1, 1, 0, 3, 7, 0, 0, 0, 0, 0, 0));
        wait_idle("R6");
        chk("R6 code 7 gives 64", nstarts, 64);
        rd(3'd4, v); chk("R8 saturate", v, 32'hFFFF);
    endtask

    task automatic t_scan();
        logic [31:0] v;
        reset_run();
        samp_val[2] = 16'h0002; samp_val[5] = 16'h0005;
        samp_val[13] = 16'h000D; samp_val[15] = 16'h00F0;
        wr(3'd1, 32'hA024);
        wr(3'd0, ctl(1, 1, 1, 3, 0, 0, 0, 0, 0, 1, 0));
        wait_idle("R4");
        chk("R4 four channels", nstarts, 4);
        chk("R4 order 0", chlog[0], 2);
        chk("R4 order 1", chlog[1], 5);
        chk("R4 order 2", chlog[2], 13);
        chk("R4 order 3", chlog[3], 15);
        rd(3'd4, v); chk("R4 last result", v, 32'h00F0);
        rd(3'd0, v); chk("R4 eos flag", {31'd0, v[19]}, 1);
        chk("R12 irq eos", {31'd0, irq}, 1);
        // empty mask
        reset_run();
        wr(3'd1, 32'h0);
        wr(3'd0, ctl(1, 1, 1, 3, 0, 0, 0, 0, 0, 0, 0));
        repeat (8) @(negedge clk);
        chk("R4 empty mask no conversion", nstarts, 0);
        rd(3'd0, v); chk("R4 empty mask eos, idle", {v[19], v[0]}, 2'b10);
    endtask

    task automatic t_cont();
        logic [31:0] v;
        reset_run();
        samp_val[4] = 16'h0300;
        wr(3'd3, 32'd4);
        wr(3'd2, 32'h0200);
        wr(3'd0, ctl(1, 1, 2, 3, 0, 0, 1, 0, 0, 0, 1));
        wait_idle("R5");
        chk("R5 halt after hit (gt)", nstarts, 1);
        rd(3'd0, v); chk("R9 cmp flag gt", {31'd0, v[20]}, 1);
        chk("R12 irq cmp", {31'd0, irq}, 1);
        // polarity 1 boundary: equal is a hit
        reset_run();
        wr(3'd2, 32'h0300);
        wr(3'd0, ctl(1, 1, 2, 3, 0, 0, 1, 1, 0, 0, 0));
        wait_idle("R9");
        chk("R9 le equal hits", nstarts, 1);
        // polarity 1 miss keeps running
        reset_run();
        wr(3'd2, 32'h0200);
        wr(3'd0, ctl(1, 1, 2, 3, 0, 0, 1, 1, 0, 0, 0));
        repeat (200) @(negedge clk);
        rd(3'd0, v); chk("R5 still busy, no cmp", {v[20], v[0]}, 2'b01);
        chk("R5 repeats", {31'd0, nstarts > 5}, 1);
        wr(3'd0, 32'd0);
        rd(3'd0, v); chk("R5 disable stops", {31'd0, v[0]}, 0);
        // continuous scan halts on hit at ch3
        reset_run();
        samp_val[1] = 16'h0010; samp_val[3] = 16'h0500;
        wr(3'd1, 32'h000A);
        wr(3'd2, 32'h0100);
        wr(3'd0, ctl(1, 1, 3, 3, 0, 0, 1, 0, 0, 0, 0));
        wait_idle("R5");
        chk("R5 cont scan halts", nstarts, 2);
        rd(3'd0, v); chk("R5 cont scan flags", {v[20], v[19]}, 2'b11);
        // compare disabled: no hit, keeps looping
        reset_run();
        wr(3'd0, ctl(1, 1, 3, 3, 0, 0, 0, 0, 0, 0, 0));
        repeat (100) @(negedge clk);
        rd(3'd0, v); chk("R9 cmp disabled", {v[20], v[0]}, 2'b01);
        chk("R5 cont scan wraps", {31'd0, nstarts > 4}, 1);
        chk("R5 wrap order", chlog[2], 1);
        wr(3'd0, 32'd0);
    endtask

    task automatic pulse(input int i);
        @(negedge clk); trig_in[i] = 1'b1;
        @(negedge clk); trig_in[i] = 1'b0;
    endtask

    task automatic t_trig();
        reset_run();
        samp_val[0] = 16'h0007;
        wr(3'd3, 32'd0);
        wr(3'd0, ctl(0, 1, 0, 3, 0, 5, 0, 0, 0, 0, 0));
        pulse(3);
        repeat (10) @(negedge clk);
        chk("R10 wrong trigger ignored", nstarts, 0);
        pulse(5);
        pulse(5);
        wait_idle("R10");
        chk("R10 selected trigger, busy ignores", nstarts, 1);
        wr(3'd0, ctl(1, 1, 0, 3, 0, 5, 0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        chk("R10 go bit needs source 0", nstarts, 1);
        wr(3'd0, ctl(0, 0, 0, 3, 0, 5, 0, 0, 0, 0, 0));
        pulse(5);
        repeat (10) @(negedge clk);
        chk("R10 disabled ignores", nstarts, 1);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        reset_run();
        wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1));
        rd(3'd0, v); chk("R11 force done", {31'd0, v[18]}, 1);
        chk("R12 irq forced", {31'd0, irq}, 1);
        wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
        rd(3'd0, v); chk("R11 clear done", {31'd0, v[18]}, 0);
        chk("R12 irq cleared", {31'd0, irq}, 0);
        wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2));
        rd(3'd0, v); chk("R11 force eos", {31'd0, v[19]}, 1);
        chk("R12 eos without enable", {31'd0, irq}, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) samp_val[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_accum();
        t_scan();
        t_cont();
        t_trig();
        t_flags();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule